// File: doc/BRIEF.md
# Event-to-Interrupt Translation Table

This block turns a message-signalled event, named by a device number and an event number, into an interrupt ID and a target processor number. The translation has two steps. An event entry gives an interrupt ID and a collection. The collection table then gives the processor that the collection is bound to. Software-style commands enter through one valid/ready port and run strictly one at a time, in arrival order. The commands bind devices, bind collections, map events, raise events and refresh the enable cache.

Each interrupt has an enable bit in two places:

- A shadow copy, written through a separate configuration port.
- A cached copy, the only one a trigger consults.

The cache picks up a shadow value only when a single-entry or per-collection refresh command reaches that interrupt. A configuration write therefore has no effect on delivery until it is followed by such a command.

Table sizes are parameters. The defaults are 8 devices, 16 event slots per device, 8 collections and 128 interrupts numbered from 8192. The event table is a plain synchronous RAM. The valid bits sit in flops beside it so that reset can clear them.

Top module: `evt_xlate`

## Requirements
- R1: After reset, `cmd_ready` is 1 and `irq_valid` and `drop_err` are 0. Every table is empty and every cached enable is clear, so a trigger issued right after reset produces no interrupt and raises `drop_err`.
- R2: A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both 1. Opcode values are 0 bind-device, 1 bind-collection, 2 map-event, 3 trigger, 4 refresh-one and 5 refresh-collection. Bind and map commands leave `cmd_ready` high. Trigger and refresh-one hold it low for exactly one cycle. Refresh-collection holds it low for DEV_N*EVT_N+1 cycles (129 by default).
- R3: A trigger whose device is bound, whose event is below the device's size, whose event is mapped, whose collection is bound and whose interrupt is enabled in the cache pulses `irq_valid` for one cycle. The pulse comes after the second clock edge that follows acceptance. It carries the mapped interrupt ID on `irq_id` and the collection's processor number on `irq_tgt`.
- R4: A map-event command whose `cmd_int` lies outside 8192 to 8192+LPI_N-1 changes nothing. It pulses `drop_err` in the cycle after acceptance, and a later trigger of that event reports `drop_err`.
- R5: Bind-device with `cmd_vld`=0 removes the device, and its later triggers give no interrupt and set `drop_err`. Any bind-device command discards every event mapping of that device.
- R6: A trigger for an unmapped event, or for an event number not below the device's size (`cmd_size`), gives no interrupt. It pulses `drop_err` for one cycle, at the same point an interrupt would have appeared.
- R7: A trigger whose cached enable is clear gives neither an interrupt nor `drop_err`.
- R8: A configuration write (`cfg_we`, `cfg_int`, `cfg_en`) changes only the shadow enable. Trigger results stay as before until a refresh command covers that interrupt.
- R9: Refresh-one (device, event) copies the shadow enable of the interrupt mapped there into the cache.
- R10: Refresh-collection copies shadow enables into the cache for every mapped event whose collection equals `cmd_col`. Interrupts mapped to other collections keep their cached enables.
- R11: An event may be mapped to an unbound collection. Its triggers are dropped without `drop_err` until the collection is bound, and deliver after that.
- R12: Rebinding a collection to a new processor changes `irq_tgt` for all later triggers routed through it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block can take a command |
| cmd_op | input | 3 | Opcode (see R2) |
| cmd_dev | input | log2(DEV_N) | Device number |
| cmd_evt | input | log2(EVT_N) | Event number |
| cmd_col | input | log2(COL_N) | Collection number |
| cmd_int | input | INT_W | Interrupt ID for map-event |
| cmd_tgt | input | TGT_W | Processor number for bind-collection |
| cmd_size | input | log2(EVT_N)+1 | Number of event slots for bind-device |
| cmd_vld | input | 1 | Valid flag for bind commands |
| cfg_we | input | 1 | Shadow enable write strobe |
| cfg_int | input | INT_W | Interrupt ID written |
| cfg_en | input | 1 | Enable value written |
| irq_valid | output | 1 | One-cycle interrupt output strobe |
| irq_id | output | INT_W | Delivered interrupt ID |
| irq_tgt | output | TGT_W | Delivered processor number |
| drop_err | output | 1 | One-cycle pulse for a dropped or rejected command |

## Verification
Trigger and refresh-one results become visible after the second rising edge following acceptance: one edge to read the event RAM, one to register the outcome. The bench samples them at the second falling edge after the accepting edge. Map-event rejection is registered on the accepting edge, so it is sampled at the first falling edge. The busy time of refresh-collection is measured by counting falling edges with `cmd_ready` low until it rises.

// File: rtl/evt_xlate_pkg.sv
package evt_xlate_pkg;
  typedef enum logic [2:0] {
    OP_BIND_DEV = 3'd0,
    OP_BIND_COL = 3'd1,
    OP_MAP_EVT  = 3'd2,
    OP_TRIGGER  = 3'd3,
    OP_REF_ONE  = 3'd4,
    OP_REF_COL  = 3'd5
  } xl_op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOOK,
    ST_SWEEP
  } xl_st_e;
endpackage

// File: rtl/xl_ram.sv
module xl_ram #(
  parameter int W = 10,
  parameter int D = 128
) (
  input  logic                 clk,
  input  logic                 we,
  input  logic [$clog2(D)-1:0] waddr,
  input  logic [W-1:0]         wdata,
  input  logic [$clog2(D)-1:0] raddr,
  output logic [W-1:0]         rdata
);
  logic [W-1:0] mem [D];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/xl_cfg.sv
module xl_cfg #(
  parameter int N = 128
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 set_we,
  input  logic [$clog2(N)-1:0] set_idx,
  input  logic                 set_en,
  input  logic                 ref_we,
  input  logic [$clog2(N)-1:0] ref_idx,
  input  logic [$clog2(N)-1:0] rd_idx,
  output logic                 rd_en
);
  logic [N-1:0] shadow_q;
  logic [N-1:0] cache_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow_q <= '0;
      cache_q  <= '0;
    end else begin
      if (set_we) shadow_q[set_idx] <= set_en;
      if (ref_we) cache_q[ref_idx]  <= shadow_q[ref_idx];
    end
  end

  assign rd_en = cache_q[rd_idx];

  // R8
  cache_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !ref_we |=> $stable(cache_q));

  // R9
  refresh_copy_chk: assert property (@(posedge clk) disable iff (rst)
    ref_we |=> cache_q[$past(ref_idx)] == $past(shadow_q[ref_idx]));
endmodule

// File: rtl/evt_xlate.sv
module evt_xlate
  import evt_xlate_pkg::*;
#(
  parameter int DEV_N    = 8,
  parameter int COL_N    = 8,
  parameter int EVT_N    = 16,
  parameter int LPI_N    = 128,
  parameter int INT_W    = 16,
  parameter int TGT_W    = 4,
  parameter int INT_BASE = 8192
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       cmd_valid,
  output logic                       cmd_ready,
  input  logic [2:0]                 cmd_op,
  input  logic [$clog2(DEV_N)-1:0]   cmd_dev,
  input  logic [$clog2(EVT_N)-1:0]   cmd_evt,
  input  logic [$clog2(COL_N)-1:0]   cmd_col,
  input  logic [INT_W-1:0]           cmd_int,
  input  logic [TGT_W-1:0]           cmd_tgt,
  input  logic [$clog2(EVT_N):0]     cmd_size,
  input  logic                       cmd_vld,
  input  logic                       cfg_we,
  input  logic [INT_W-1:0]           cfg_int,
  input  logic                       cfg_en,
  output logic                       irq_valid,
  output logic [INT_W-1:0]           irq_id,
  output logic [TGT_W-1:0]           irq_tgt,
  output logic                       drop_err
);
  localparam int DEV_W  = $clog2(DEV_N);
  localparam int COL_W  = $clog2(COL_N);
  localparam int EVT_W  = $clog2(EVT_N);
  localparam int LPI_W  = $clog2(LPI_N);
  localparam int SLOTS  = DEV_N * EVT_N;
  localparam int SLOT_W = DEV_W + EVT_W;
  localparam int ENT_W  = COL_W + LPI_W;

  // device and collection tables
  logic [DEV_N-1:0]   dev_ok;
  logic [EVT_W:0]     dev_size [DEV_N];
  logic [COL_N-1:0]   col_ok;
  logic [TGT_W-1:0]   col_tgt  [COL_N];
  logic [SLOTS-1:0]   ite_ok;

  // latched command and control
  xl_st_e             state;
  xl_op_e             c_op;
  logic [COL_W-1:0]   c_col;
  logic [SLOT_W-1:0]  c_slot;
  logic               c_ok;
  logic [SLOT_W:0]    ptr;
  logic [SLOT_W-1:0]  sw_addr;
  logic               sw_pend;

  logic               take;
  logic [SLOT_W-1:0]  in_slot;
  logic               in_range;
  logic [INT_W-1:0]   map_rel, cfg_rel;
  logic               map_ok, cfg_ok;
  logic [SLOT_W-1:0]  raddr;
  logic [ENT_W-1:0]   rdata;
  logic [COL_W-1:0]   e_col;
  logic [LPI_W-1:0]   e_idx;
  logic               hit, sw_hit, ref_we, en_bit;

  assign cmd_ready = (state == ST_IDLE);
  assign take      = cmd_valid && cmd_ready;
  assign in_slot   = {cmd_dev, cmd_evt};
  assign in_range  = dev_ok[cmd_dev] && ({1'b0, cmd_evt} < dev_size[cmd_dev]);
  assign map_rel   = cmd_int - INT_W'(INT_BASE);
  assign cfg_rel   = cfg_int - INT_W'(INT_BASE);
  assign map_ok    = (cmd_int >= INT_W'(INT_BASE)) && (map_rel < INT_W'(LPI_N));
  assign cfg_ok    = (cfg_int >= INT_W'(INT_BASE)) && (cfg_rel < INT_W'(LPI_N));
  assign raddr     = (state == ST_SWEEP) ? ptr[SLOT_W-1:0] : in_slot;
  assign e_col     = rdata[ENT_W-1 -: COL_W];
  assign e_idx     = rdata[LPI_W-1:0];
  assign hit       = c_ok && ite_ok[c_slot];
  assign sw_hit    = sw_pend && ite_ok[sw_addr] && (e_col == c_col);
  assign ref_we    = ((state == ST_LOOK) && (c_op == OP_REF_ONE) && hit) ||
                     ((state == ST_SWEEP) && sw_hit);

  xl_ram #(.W(ENT_W), .D(SLOTS)) u_ite (
    .clk   (clk),
    .we    (take && (xl_op_e'(cmd_op) == OP_MAP_EVT) && in_range && map_ok),
    .waddr (in_slot),
    .wdata ({cmd_col, map_rel[LPI_W-1:0]}),
    .raddr (raddr),
    .rdata (rdata)
  );

  xl_cfg #(.N(LPI_N)) u_cfg (
    .clk     (clk),
    .rst     (rst),
    .set_we  (cfg_we && cfg_ok),
    .set_idx (cfg_rel[LPI_W-1:0]),
    .set_en  (cfg_en),
    .ref_we  (ref_we),
    .ref_idx (e_idx),
    .rd_idx  (e_idx),
    .rd_en   (en_bit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      dev_ok    <= '0;
      col_ok    <= '0;
      ite_ok    <= '0;
      c_op      <= OP_BIND_DEV;
      c_col     <= '0;
      c_slot    <= '0;
      c_ok      <= 1'b0;
      ptr       <= '0;
      sw_addr   <= '0;
      sw_pend   <= 1'b0;
      irq_valid <= 1'b0;
      irq_id    <= '0;
      irq_tgt   <= '0;
      drop_err  <= 1'b0;
      for (int d = 0; d < DEV_N; d++) dev_size[d] <= '0;
      for (int c = 0; c < COL_N; c++) col_tgt[c]  <= '0;
    end else begin
      irq_valid <= 1'b0;
      drop_err  <= 1'b0;
      case (state)
        ST_IDLE: if (take) begin
          c_op   <= xl_op_e'(cmd_op);
          c_col  <= cmd_col;
          c_slot <= in_slot;
          c_ok   <= in_range;
          case (xl_op_e'(cmd_op))
            OP_BIND_DEV: begin
              dev_ok[cmd_dev]   <= cmd_vld;
              dev_size[cmd_dev] <= cmd_size;
              for (int e = 0; e < EVT_N; e++) ite_ok[{cmd_dev, EVT_W'(e)}] <= 1'b0;
            end
            OP_BIND_COL: begin
              col_ok[cmd_col]  <= cmd_vld;
              col_tgt[cmd_col] <= cmd_tgt;
            end
            OP_MAP_EVT: begin
              if (in_range && map_ok) ite_ok[in_slot] <= 1'b1;
              else drop_err <= 1'b1;
            end
            OP_TRIGGER, OP_REF_ONE: state <= ST_LOOK;
            OP_REF_COL: begin
              state   <= ST_SWEEP;
              ptr     <= '0;
              sw_pend <= 1'b0;
            end
            default: ;
          endcase
        end
        ST_LOOK: begin
          state <= ST_IDLE;
          if (!hit) drop_err <= 1'b1;
          else if ((c_op == OP_TRIGGER) && col_ok[e_col] && en_bit) begin
            irq_valid <= 1'b1;
            irq_id    <= INT_W'(INT_BASE) + INT_W'(e_idx);
            irq_tgt   <= col_tgt[e_col];
          end
        end
        ST_SWEEP: begin
          if (ptr == (SLOT_W+1)'(SLOTS)) begin
            state   <= ST_IDLE;
            sw_pend <= 1'b0;
          end else begin
            sw_addr <= ptr[SLOT_W-1:0];
            ptr     <= ptr + 1'b1;
            sw_pend <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R3
  irq_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    irq_valid |=> !irq_valid);

  // R2
  trig_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready && cmd_op == 3'd3) |=> !cmd_ready);

  // R4
  irq_range_chk: assert property (@(posedge clk) disable iff (rst)
    irq_valid |-> (irq_id >= INT_W'(INT_BASE)) && (irq_id < INT_W'(INT_BASE + LPI_N)));

  // R6
  err_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(irq_valid && drop_err));
endmodule

// File: tb/sim_evt_xlate.sv
`timescale 1ns/1ps
module sim_evt_xlate;
  localparam int SLOTS = 128;
  localparam logic [2:0] BDV = 3'd0, BCL = 3'd1, MAP = 3'd2, TRG = 3'd3,
                         R1E = 3'd4, RCL = 3'd5, CFG = 3'd7;

  typedef struct packed {
    logic [2:0]  op;
    logic [2:0]  dev;
    logic [3:0]  evt;
    logic [2:0]  col;
    logic [15:0] id;
    logic [3:0]  tgt;
    logic [4:0]  size;
    logic        vld;
    logic        chk;
    logic        e_irq;
    logic [3:0]  e_tgt;
    logic        e_err;
  } vec_t;

  // op dev evt col id tgt size vld chk e_irq e_tgt e_err
  localparam vec_t VEC [40] = '{
    '{TRG, 3'd0, 4'd0,  3'd0, 16'h0000, 4'd0, 5'd0,  1'b0, 1'b1, 1'b0, 4'd0, 1'b1}, // 0 R1
    '{BDV, 3'd2, 4'd0,  3'd0, 16'h0000, 4'd0, 5'd8,  1'b1, 1'b0, 1'b0, 4'd0, 1'b0},
    '{BDV, 3'd7, 4'd0,  3'd0, 16'h0000, 4'd0, 5'd16, 1'b1, 1'b0, 1'b0, 4'd0, 1'b0},
    '{BCL, 3'd0, 4'd0,  3'd3, 16'h0000, 4'd3, 5'd0,  1'b1, 1'b0, 1'b0, 4'd0, 1'b0},
    '{BCL, 3'd0, 4'd0,  3'd2, 16'h0000, 4'd2, 5'd0,  1'b1, 1'b0, 1'b0, 4'd0, 1'b0},
    '{MAP, 3'd2, 4'd5,  3'd3, 16'h2003, 4'd0, 5'd0,  1'b0, 1'b1, 1'b0, 4'd0, 1'b0},
    '{MAP, 3'd7, 4'd15, 3'd2, 16'h2004, 4'd0, 5'd0,  1'b0, 1'b1, 1'b0, 4'd0, 1'b0},
    '{CFG, 3'd0, 4'd0,  3'd0, 16'h2003, 4'd0, 5'd0,  1'b1, 1'b0, 1'b0, 4'd0, 1'b0},
    '{CFG, 3'd0, 4'd0,  3'd0, 16'h2004, 4'd0, 5'd0,  1'b1, 1'b0, 1'b0, 4'd0, 1'b0},
    '{TRG, 3'd2, 4'd5,  3'd0, 16'h2003, 4'd0, 5'd0,  1'b0, 1'b1, 1'b0, 4'd0, 1'b0}, // 9 R8
    '{R1E, 3'd2, 4'd5,  3'd0, 16'h0000, 4'd0, 5'd0,  1'b0, 1'b1, 1'b0, 4'd0, 1'b0},
    '{TRG, 3'd2, 4'd5,  3'd0, 16'h2003, 4'd0, 5'd0,  1'b0, 1'b1, 1'b1, 4'd3, 1'b0}, // 11 R3 R9
    '{TRG, 3'd7, 4'd15, 3'd0, 16'h2004, 4'd0, 5'd0,  1'b0, 1'b1, 1'b0, 4'd0, 1'b0}, // 12 R8
    '{RCL, 3'd0, 4'd0,  3'd2, 16'h0000, 4'd0, 5'd0,  1'b0, 1'b0, 1'b0, 4'd0, 1'b0},
    '{TRG, 3'd7, 4'd15, 3'd0, 16'h2004, 4'd0, 5'd0,  1'b0, 1'b1, 1'b1, 4'd2, 1'b0}, // 14 R10
    '{TRG, 3'd2, 4'd8,  3'd0, 16'h0000, 4'd0, 5'd0,  1'b0, 1'b1, 1'b0, 4'd0, 1'b1}, // 15 R6
    '{TRG, 3'd2, 4'd6,  3'd0, 16'h0000, 4'd0, 5'd0,  1'b0, 1'b1, 1'b0, 4'd0, 1'b1}, // 16 R6
    '{MAP, 3'd2, 4'd1,  3'd5, 16'h2010, 4'd0, 5'd0,  1'b0, 1'b0, 1'b0, 4'd0, 1'b0},
    '{CFG, 3'd0, 4'd0,  3'd0, 16'h2010, 4'd0, 5'd0,  1'b1, 1'b0, 1'b0, 4'd0, 1'b0},
    '{R1E, 3'd2, 4'd1,  3'd0, 16'h0000, 4'd0, 5'd0,  1'b0, 1'b0, 1'b0, 4'd0, 1'b0},
    '{TRG, 3'd2, 4'd1,  3'd0, 16'h2010, 4'd0, 5'd0,  1'b0, 1'b1, 1'b0, 4'd0, 1'b0}, // 20 R11
    '{BCL, 3'd0, 4'd0,  3'd5, 16'h0000, 4'd9, 5'd0,  1'b1, 1'b0, 1'b0, 4'd0, 1'b0},
    '{TRG, 3'd2, 4'd1,  3'd0, 16'h2010, 4'd0, 5'd0,  1'b0, 1'b1, 1'b1, 4'd9, 1'b0}, // 22 R11
    '{BCL, 3'd0, 4'd0,  3'd3, 16'h0000, 4'd6, 5'd0,  1'b1, 1'b0, 1'b0, 4'd0, 1'b0},
    '{TRG, 3'd2, 4'd5,  3'd0, 16'h2003, 4'd0, 5'd0,  1'b0, 1'b1, 1'b1, 4'd6, 1'b0}, // 24 R12
    '{CFG, 3'd0, 4'd0,  3'd0, 16'h2003, 4'd0, 5'd0,  1'b0, 1'b0, 1'b0, 4'd0, 1'b0},
    '{TRG, 3'd2, 4'd5,  3'd0, 16'h2003, 4'd0, 5'd0,  1'b0, 1'b1, 1'b1, 4'd6, 1'b0}, // 26 R8
    '{R1E, 3'd2, 4'd5,  3'd0, 16'h0000, 4'd0, 5'd0,  1'b0, 1'b0, 1'b0, 4'd0, 1'b0},
    '{TRG, 3'd2, 4'd5,  3'd0, 16'h2003, 4'd0, 5'd0,  1'b0, 1'b1, 1'b0, 4'd0, 1'b0}, // 28 R7
    '{MAP, 3'd2, 4'd2,  3'd3, 16'h2080, 4'd0, 5'd0,  1'b0, 1'b1, 1'b0, 4'd0, 1'b1}, // 29 R4
    '{TRG, 3'd2, 4'd2,  3'd0, 16'h0000, 4'd0, 5'd0,  1'b0, 1'b1, 1'b0, 4'd0, 1'b1}, // 30 R4
    '{MAP, 3'd2, 4'd3,  3'd3, 16'h1FFF, 4'd0, 5'd0,  1'b0, 1'b1, 1'b0, 4'd0, 1'b1}, // 31 R4
    '{CFG, 3'd0, 4'd0,  3'd0, 16'h2010, 4'd0, 5'd0,  1'b0, 1'b0, 1'b0, 4'd0, 1'b0},
    '{RCL, 3'd0, 4'd0,  3'd2, 16'h0000, 4'd0, 5'd0,  1'b0, 1'b0, 1'b0, 4'd0, 1'b0},
    '{TRG, 3'd2, 4'd1,  3'd0, 16'h2010, 4'd0, 5'd0,  1'b0, 1'b1, 1'b1, 4'd9, 1'b0}, // 34 R10
    '{BDV, 3'd2, 4'd0,  3'd0, 16'h0000, 4'd0, 5'd8,  1'b0, 1'b0, 1'b0, 4'd0, 1'b0},
    '{TRG, 3'd2, 4'd1,  3'd0, 16'h0000, 4'd0, 5'd0,  1'b0, 1'b1, 1'b0, 4'd0, 1'b1}, // 36 R5
    '{BDV, 3'd2, 4'd0,  3'd0, 16'h0000, 4'd0, 5'd8,  1'b1, 1'b0, 1'b0, 4'd0, 1'b0},
    '{TRG, 3'd2, 4'd1,  3'd0, 16'h0000, 4'd0, 5'd0,  1'b0, 1'b1, 1'b0, 4'd0, 1'b1}, // 38 R5
    '{TRG, 3'd7, 4'd15, 3'd0, 16'h2004, 4'd0, 5'd0,  1'b0, 1'b1, 1'b1, 4'd2, 1'b0}  // 39 R5
  };
  localparam string TAG [40] = '{
    "R1", "", "", "", "", "", "", "", "", "R8", "", "R3/R9", "R8", "", "R10", "R6", "R6",
    "", "", "", "R11", "", "R11", "", "R12", "", "R8", "", "R7", "R4", "R4", "R4", "", "",
    "R10", "", "R5", "", "R5", "R5"};

  logic clk = 1'b0, rst = 1'b1;
  logic cmd_valid = 1'b0, cmd_ready;
  logic [2:0] cmd_op = '0, cmd_dev = '0, cmd_col = '0;
  logic [3:0] cmd_evt = '0, cmd_tgt = '0;
  logic [15:0] cmd_int = '0, cfg_int = '0;
  logic [4:0] cmd_size = '0;
  logic cmd_vld = 1'b0, cfg_we = 1'b0, cfg_en = 1'b0;
  logic irq_valid, drop_err;
  logic [15:0] irq_id;
  logic [3:0] irq_tgt;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  evt_xlate u0 (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_dev(cmd_dev), .cmd_evt(cmd_evt), .cmd_col(cmd_col),
    .cmd_int(cmd_int), .cmd_tgt(cmd_tgt), .cmd_size(cmd_size), .cmd_vld(cmd_vld),
    .cfg_we(cfg_we), .cfg_int(cfg_int), .cfg_en(cfg_en),
    .irq_valid(irq_valid), .irq_id(irq_id), .irq_tgt(irq_tgt), .drop_err(drop_err));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send(input vec_t v);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1; cmd_op = v.op; cmd_dev = v.dev; cmd_evt = v.evt;
    cmd_col = v.col; cmd_int = v.id; cmd_tgt = v.tgt; cmd_size = v.size; cmd_vld = v.vld;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic check_out(input vec_t v, input string req);
    check(irq_valid == v.e_irq, req, irq_valid, v.e_irq);
    if (v.e_irq) begin
      check(irq_id == v.id, req, irq_id, v.id);
      check(irq_tgt == v.e_tgt, req, irq_tgt, v.e_tgt);
    end
    check(drop_err == v.e_err, req, drop_err, v.e_err);
  endtask

  initial begin
    #4_000_000;
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(cmd_ready == 1'b1, "R1", cmd_ready, 1);
    check(irq_valid == 1'b0, "R1", irq_valid, 0);
    check(drop_err == 1'b0, "R1", drop_err, 0);

    for (int i = 0; i < 40; i++) begin
      if (VEC[i].op == CFG) begin
        cfg_we = 1'b1; cfg_int = VEC[i].id; cfg_en = VEC[i].vld;
        @(negedge clk);
        cfg_we = 1'b0;
      end else begin
        send(VEC[i]);
        if (VEC[i].op == TRG || VEC[i].op == R1E) @(negedge clk);
        if (VEC[i].chk) check_out(VEC[i], TAG[i]);
        while (!cmd_ready) @(negedge clk);
      end
    end

    // R2 trigger holds ready low one cycle
    begin
      vec_t t = VEC[39];
      send(t);
      check(cmd_ready == 1'b0, "R2", cmd_ready, 0);
      @(negedge clk);
      check(cmd_ready == 1'b1, "R2", cmd_ready, 1);
      check_out(t, "R2");
    end

    // R2 bind commands keep ready high
    begin
      vec_t b = VEC[3];
      send(b);
      check(cmd_ready == 1'b1, "R2", cmd_ready, 1);
    end

    // R2 refresh-collection busy length
    begin
      vec_t s = VEC[13];
      int n = 0;
      send(s);
      while (!cmd_ready) begin
        n++;
        @(negedge clk);
      end
      check(n == SLOTS + 1, "R2", n, SLOTS + 1);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule